// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer with Prescaler

This block watches over a processor by counting machine-cycle ticks and raising a reset request when the count reaches a programmable limit before software services it. The limit is a base tick count multiplied by a power of two, from 1 to 128. The multiplier comes from a 3-bit prescaler field in an 8-bit control register. The same register picks the operating mode, the idle-mode behaviour and whether the external reset pin is driven.

In software mode, an enable bit runs or freezes the counter, and a self-clearing restart bit clears it. In hardware mode, neither bit has any effect. The watchdog is armed by writing the byte pair 0x1E then 0xE1 to a separate write-only restart port, and the same pair refreshes it. Once armed, only the block reset can disarm it. On a timeout the counter returns to zero and a reset pulse of fixed length in ticks is produced. The pulse also drives the reset pin unless that drive is disabled.

Top module: `wdog_top`

## Requirements
- R1: After reset, `core_rst_req`, `pin_drive` and `pin_oe` are 0, `cfg_rdata` reads 0x00, and no reset request occurs while the watchdog stays disabled.
- R2: Control register layout: bits [2:0] prescaler `ps`, bit 3 idle-stop, bit 4 pin-drive disable, bit 5 hardware mode, bit 6 restart, bit 7 enable. When the watchdog is active, ticks are 1 and the counter starts at zero from the edge that activates it, `core_rst_req` rises exactly BASE_TICKS<<ps clock edges later.
- R3: Ticks are counted only while `tick` is 1 and `pdown` is 0. Otherwise the counter holds its value.
- R4: While `idle` is 1, the counter runs if idle-stop is 0 and holds if idle-stop is 1.
- R5: In software mode, clearing the enable bit freezes the counter without clearing it. Re-enabling resumes from the frozen value.
- R6: In software mode, writing 1 to the restart bit makes it read back as 1 for one cycle. It then clears by itself, and the counter is zero on the following edge.
- R7: In hardware mode, writing 0x1E and then 0xE1 on the restart port arms the watchdog and clears the counter. `cfg_rdata` bit 7 reads back the armed state. Setting hardware mode alone does not arm it.
- R8: 0xE1 counts only if the restart-port write immediately before it was 0x1E. Any other value in between cancels the sequence.
- R9: Once armed, the hardware mode bit cannot be cleared, the restart and enable bits have no effect, and only `rst_n` disarms the watchdog.
- R10: During a timeout pulse, `pin_drive` and `pin_oe` follow `core_rst_req` when the pin-drive disable bit is 0. They stay 0 when it is 1.
- R11: The reset pulse lasts PULSE_TICKS ticks. The counter is zero after a timeout and holds during the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Machine-cycle tick enable |
| idle | input | 1 | Processor is in idle mode |
| pdown | input | 1 | Processor is in power-down mode |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data (bit 7 = active) |
| rp_we | input | 1 | Restart port write strobe |
| rp_wdata | input | 8 | Restart port write data |
| core_rst_req | output | 1 | Internal reset request pulse |
| pin_drive | output | 1 | Value driven on the reset pin |
| pin_oe | output | 1 | Output enable for the reset pin |

## Verification
The assertions take for granted that the restart bit is never written in two back-to-back cycles. They also assume that `rst_n` is the only means of disarming, and that the prescaler field may change at any time. The expiry compare uses greater-or-equal, so a smaller limit never lets the counter run past it. The stimulus makes every write a single-cycle strobe driven between clock edges. It leaves gaps between restart bit writes, and it only reprograms the prescaler while the counter is stopped at zero or with the same value. This keeps every expected timeout edge exactly computable from the requirements.

// File: rtl/wdog_pkg.sv
// Package: shared constants and control-register layout for the watchdog.
// Assumes an 8-bit control register; field order is fixed by the struct.
package wdog_pkg;

    localparam logic [7:0] UNLOCK_FIRST  = 8'h1E;
    localparam logic [7:0] UNLOCK_SECOND = 8'hE1;

    // Control register fields, bit 7 down to bit 0.
    typedef struct packed {
        logic       sw_en;     // bit 7: enable (software mode)
        logic       kick;      // bit 6: restart request, self-clearing
        logic       hw_mode;   // bit 5: hardware mode select
        logic       pin_off;   // bit 4: suppress reset-pin drive
        logic       idle_off;  // bit 3: stop counting in idle
        logic [2:0] ps;        // bits 2:0: prescaler exponent
    } wdog_cfg_t;

endpackage

// File: rtl/wdog_unlock.sv
// Module: restart-port sequence detector.
// Flags seq_ok on the write of the second unlock byte when the write just
// before it carried the first unlock byte. Any other byte cancels progress.
module wdog_unlock
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       seq_ok
);

    logic got_first_q;

    // Remember whether the latest restart-port write was the first byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_first_q <= 1'b0;
        end else if (wr) begin
            got_first_q <= (wdata == UNLOCK_FIRST);
        end
    end

    // Second byte completes the pair only right after the first byte.
    always_comb begin
        seq_ok = wr && got_first_q && (wdata == UNLOCK_SECOND);
    end

    AST_SEQ_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        seq_ok |=> !got_first_q);  // R8

endmodule

// File: rtl/wdog_ctrl.sv
// Module: control register, mode lock and arming state.
// Assumes the restart bit is not written in two consecutive cycles.
// Produces the active flag and a one-shot counter clear request.
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       seq_ok,
    output logic [2:0] ps,
    output logic       idle_off,
    output logic       pin_off,
    output logic       active,
    output logic       clr_req,
    output logic [7:0] rdata
);

    wdog_cfg_t cfg_q;
    wdog_cfg_t wr_val;
    logic      armed_q;
    logic      hw_next;

    // Decode the write and keep hardware mode locked once armed.
    always_comb begin
        wr_val  = wdog_cfg_t'(cfg_wdata);
        hw_next = armed_q | wr_val.hw_mode;
    end

    // Register fields, self-clearing restart bit and sticky arm flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (cfg_we) begin
                cfg_q.sw_en    <= wr_val.sw_en;
                cfg_q.hw_mode  <= hw_next;
                cfg_q.pin_off  <= wr_val.pin_off;
                cfg_q.idle_off <= wr_val.idle_off;
                cfg_q.ps       <= wr_val.ps;
            end
            cfg_q.kick <= cfg_we && wr_val.kick && !hw_next;
            if (cfg_q.hw_mode && seq_ok) begin
                armed_q <= 1'b1;
            end
        end
    end

    // Mode-dependent outputs and read-back image.
    always_comb begin
        active   = cfg_q.hw_mode ? armed_q : cfg_q.sw_en;
        clr_req  = (cfg_q.kick && !cfg_q.hw_mode) || (seq_ok && cfg_q.hw_mode);
        ps       = cfg_q.ps;
        idle_off = cfg_q.idle_off;
        pin_off  = cfg_q.pin_off;
        rdata    = {active, cfg_q.kick, cfg_q.hw_mode, cfg_q.pin_off,
                    cfg_q.idle_off, cfg_q.ps};
    end

    AST_KICK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.kick && !cfg_we |=> !cfg_q.kick);  // R6
    AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> armed_q && cfg_q.hw_mode && active);  // R9
    AST_KICK_NOT_IN_HW: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> !cfg_q.kick);  // R9

endmodule

// File: rtl/wdog_count.sv
// Module: timeout counter with power-of-two prescaled limit.
// Assumes run is already gated by tick, mode, power and idle state.
// Expiry uses >= so a reduced limit never lets the count run past it.
module wdog_count #(
    parameter int BASE_TICKS = 16384,
    parameter int CNT_W      = $clog2(BASE_TICKS) + 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clr,
    input  logic [2:0] ps,
    output logic       expire
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Limit and expiry decision for the current prescaler setting.
    always_comb begin
        limit  = CNT_W'(BASE_TICKS) << ps;
        expire = run && !clr && (cnt_q >= limit - CNT_W'(1));
    end

    // Count ticks, clearing on request or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || expire) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !clr |=> $stable(cnt_q));  // R5
    AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> cnt_q == '0);  // R11

endmodule

// File: rtl/wdog_pulse.sv
// Module: stretches a one-cycle timeout into a PULSE_TICKS-tick pulse.
// Assumes start is never raised while the pulse is busy.
module wdog_pulse #(
    parameter int PULSE_TICKS = 4,
    parameter int PW          = $clog2(PULSE_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    output logic busy
);

    logic [PW-1:0] left_q;

    // Load on start, count down on each tick until empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= PW'(PULSE_TICKS);
        end else if (tick && left_q != '0) begin
            left_q <= left_q - PW'(1);
        end
    end

    // Pulse is active while ticks remain.
    always_comb begin
        busy = (left_q != '0);
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);  // R11
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);  // R11

endmodule

// File: rtl/wdog_top.sv
// Module: dual-mode watchdog top level.
// Joins register control, the unlock detector, the counter and the pulse
// stretcher. Counting is gated by tick, power-down, idle and pulse state.
module wdog_top #(
    parameter int BASE_TICKS  = 16384,
    parameter int PULSE_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       idle,
    input  logic       pdown,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       rp_we,
    input  logic [7:0] rp_wdata,
    output logic       core_rst_req,
    output logic       pin_drive,
    output logic       pin_oe
);

    localparam int CNT_W = $clog2(BASE_TICKS) + 8;

    logic       seq_ok;
    logic [2:0] ps;
    logic       idle_off;
    logic       pin_off;
    logic       active;
    logic       clr_req;
    logic       run;
    logic       expire;
    logic       busy;

    wdog_unlock u_unlock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (rp_we),
        .wdata  (rp_wdata),
        .seq_ok (seq_ok)
    );

    wdog_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .seq_ok    (seq_ok),
        .ps        (ps),
        .idle_off  (idle_off),
        .pin_off   (pin_off),
        .active    (active),
        .clr_req   (clr_req),
        .rdata     (cfg_rdata)
    );

    // Counting gate: active, ticking, awake and not mid-pulse.
    always_comb begin
        run = tick && active && !pdown && !(idle && idle_off) && !busy;
    end

    wdog_count #(
        .BASE_TICKS (BASE_TICKS),
        .CNT_W      (CNT_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .clr    (clr_req),
        .ps     (ps),
        .expire (expire)
    );

    wdog_pulse #(
        .PULSE_TICKS (PULSE_TICKS)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .start (expire),
        .busy  (busy)
    );

    // Reset outputs: internal request always, pin only when allowed.
    always_comb begin
        core_rst_req = busy;
        pin_oe       = busy && !pin_off;
        pin_drive    = busy && !pin_off;
    end

    AST_PIN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> core_rst_req && !cfg_rdata[4]);  // R10
    AST_TIMEOUT_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_req) |-> $past(cfg_rdata[7]));  // R1

endmodule

// File: tb/wdog_top_tb.sv
// Bench: scoreboard of expected timeout edges against observed reset pulses.
module wdog_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 4;
    localparam int PULSE      = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       idle = 1'b0;
    logic       pdown = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       rp_we = 1'b0;
    logic [7:0] rp_wdata = '0;
    logic       core_rst_req;
    logic       pin_drive;
    logic       pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int exp_cyc_q[$];
    bit exp_pin_q[$];
    bit req_prev = 1'b0;
    int width = 0;
    int e_cyc;
    bit e_pin;
    bit done = 1'b0;

    wdog_top #(.BASE_TICKS(BASE), .PULSE_TICKS(PULSE)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .idle         (idle),
        .pdown        (pdown),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .rp_we        (rp_we),
        .rp_wdata     (rp_wdata),
        .core_rst_req (core_rst_req),
        .pin_drive    (pin_drive),
        .pin_oe       (pin_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic push(input int c, input bit p);
        exp_cyc_q.push_back(c);
        exp_pin_q.push_back(p);
    endtask

    task automatic wr_cfg(input logic [7:0] d, output int edge_c);
        cfg_we = 1'b1; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        edge_c = cyc;
    endtask

    task automatic wr_rp(input logic [7:0] d, output int edge_c);
        rp_we = 1'b1; rp_wdata = d;
        @(posedge clk); @(negedge clk);
        rp_we = 1'b0;
        edge_c = cyc;
    endtask

    task automatic wait_req(input bit v);
        while (core_rst_req !== v) @(negedge clk);
    endtask

    task automatic no_reset(input int n, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (core_rst_req) seen = 1'b1;
        end
        check(!seen, tag, int'(seen), 0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: pops expected timeout edges and checks pulse shape.
    always @(negedge clk) begin
        if (!rst_n) begin
            req_prev = 1'b0;
            width = 0;
        end else begin
            if (core_rst_req && !req_prev) begin
                if (exp_cyc_q.size() == 0) begin
                    check(1'b0, "R2 unexpected reset request", cyc, -1);
                end else begin
                    e_cyc = exp_cyc_q.pop_front();
                    e_pin = exp_pin_q.pop_front();
                    check(cyc == e_cyc, "R2 timeout edge", cyc, e_cyc);
                    check(pin_oe == e_pin && pin_drive == e_pin, "R10 pin drive",
                          int'(pin_oe), int'(e_pin));
                end
                width = 1;
            end else if (core_rst_req) begin
                width++;
            end else if (req_prev) begin
                check(width == PULSE, "R11 pulse width", width, PULSE);
            end
            req_prev = core_rst_req;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int e, d, e2, k, a, r, tmp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and no activity while disabled
        check(cfg_rdata == 8'h00, "R1 rdata after reset", cfg_rdata, 0);
        check(!core_rst_req && !pin_oe && !pin_drive, "R1 outputs after reset",
              int'(core_rst_req), 0);
        no_reset(50, "R1 disabled after reset");

        // R2: every prescaler setting in software mode
        for (int p = 0; p < 8; p++) begin
            wr_cfg(8'h80 | 8'(p), e);
            push(e + (BASE << p), 1'b1);
            wait_req(1'b1);
            wr_cfg(8'h00, tmp);
            wait_req(1'b0);
        end

        // R4: idle-stop set holds the counter, cleared lets it run
        idle = 1'b1;
        wr_cfg(8'h88, e);
        check(cfg_rdata == 8'h88, "R4 rdata idle-stop", cfg_rdata, 8'h88);
        no_reset(30, "R4 idle-stop holds");
        wr_cfg(8'h80, e);
        push(e + BASE, 1'b1);
        wait_req(1'b1);
        wr_cfg(8'h00, tmp);
        wait_req(1'b0);
        idle = 1'b0;

        // R3: power-down holds the counter
        pdown = 1'b1;
        wr_cfg(8'h80, e);
        no_reset(30, "R3 power-down holds");
        pdown = 1'b0;
        push(cyc + BASE, 1'b1);
        wait_req(1'b1);
        wr_cfg(8'h00, tmp);
        wait_req(1'b0);

        // R3: no ticks, no counting
        tick = 1'b0;
        wr_cfg(8'h80, e);
        no_reset(30, "R3 tick low holds");
        tick = 1'b1;
        push(cyc + BASE, 1'b1);
        wait_req(1'b1);
        wr_cfg(8'h00, tmp);
        wait_req(1'b0);

        // R10: pin drive disabled keeps the pin an input
        wr_cfg(8'h90, e);
        push(e + BASE, 1'b0);
        wait_req(1'b1);
        wr_cfg(8'h10, tmp);
        wait_req(1'b0);

        // R5: disable freezes, re-enable resumes
        wr_cfg(8'h81, e);
        repeat (5) @(negedge clk);
        wr_cfg(8'h01, d);
        no_reset(20, "R5 frozen while disabled");
        wr_cfg(8'h81, e2);
        push(e2 + (BASE << 1) - (d - e), 1'b1);
        wait_req(1'b1);
        wr_cfg(8'h01, tmp);
        wait_req(1'b0);

        // R6: restart bit self-clears and clears the counter
        wr_cfg(8'h81, e);
        repeat (4) @(negedge clk);
        wr_cfg(8'hC1, k);
        check(cfg_rdata == 8'hC1, "R6 restart bit reads 1", cfg_rdata, 8'hC1);
        push(k + 1 + (BASE << 1), 1'b1);
        @(negedge clk);
        check(cfg_rdata == 8'h81, "R6 restart bit self-clears", cfg_rdata, 8'h81);
        wait_req(1'b1);
        wr_cfg(8'h01, tmp);
        wait_req(1'b0);

        // R7: hardware mode alone does not arm
        wr_cfg(8'h22, tmp);
        check(cfg_rdata == 8'h22, "R7 hw mode unarmed", cfg_rdata, 8'h22);
        no_reset(30, "R7 unarmed hw mode idle");

        // R8: broken sequence does not arm
        wr_rp(8'h1E, tmp);
        wr_rp(8'h55, tmp);
        wr_rp(8'hE1, tmp);
        check(cfg_rdata[7] == 1'b0, "R8 broken pair ignored", cfg_rdata[7], 0);
        no_reset(20, "R8 still unarmed");

        // R7: proper pair arms
        wr_rp(8'h1E, tmp);
        wr_rp(8'hE1, a);
        check(cfg_rdata == 8'hA2, "R7 armed readback", cfg_rdata, 8'hA2);
        repeat (6) @(negedge clk);
        wr_rp(8'h1E, tmp);
        wr_rp(8'hE1, r);
        push(r + (BASE << 2), 1'b1);

        // R9: restart, enable and mode bits have no effect once armed
        wr_cfg(8'h42, tmp);
        check(cfg_rdata == 8'hA2, "R9 mode locked", cfg_rdata, 8'hA2);

        // R8: lone second byte after a wrong byte is not a refresh
        wr_rp(8'h1E, tmp);
        wr_rp(8'h33, tmp);
        wr_rp(8'hE1, tmp);
        wait_req(1'b1);
        wait_req(1'b0);

        // R9: only reset disarms
        do_reset();
        @(negedge clk);
        check(cfg_rdata == 8'h00, "R9 reset disarms", cfg_rdata, 0);
        no_reset(40, "R9 quiet after reset");

        check(exp_cyc_q.size() == 0, "R2 all expected timeouts seen",
              exp_cyc_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule